// File: doc/BRIEF.md
# Prescaled Timer-Counter with Buffered 16-bit Access

This block is a timer/counter that sits on an 8-bit register bus. It can count one of two sources. The first is the core's instruction-cycle tick (`tick_i`). The second is chosen edges of an external input pin, which passes through a two-flop synchronizer before edge detection. The counter runs either as an 8-bit counter, using only the low byte, or as a full 16-bit counter. A prescaler can be placed in the count path. The prescaler is an internal 8-bit counter that software cannot see, and it divides the count source by a power of two from 2 to 256.

Software reaches the counter's high byte only through a holding buffer. This lets all 16 bits be read or written without tearing. Reading the low byte captures the live high byte into the buffer at the same moment. Writing the low byte moves the buffer into the high byte and the written data into the low byte in the same cycle.

Every write to the low byte has two further effects:
- it clears the prescaler count;
- it blocks counting for the next two instruction-cycle ticks.

A wrap of the counter sets a sticky overflow flag. The interrupt output is that flag gated by an enable bit.

Top module: `tcu_top`

## Requirements
- R1: After reset, the control port (address 0) reads FFh, the low port (address 1) reads 00h, the high buffer port (address 2) reads 00h, the status port (address 3) reads 00h, and `irq_o` is 0. Control bit fields are: bit 7 run, bit 6 byte mode (1 = 8-bit), bit 5 source (1 = external pin), bit 4 edge (1 = falling), bit 3 prescaler bypass (1 = bypassed), bits 2:0 ratio select. Status bits are: bit 0 overflow flag, bit 1 interrupt enable.
- R2: In timer mode with the prescaler bypassed, the counter increments by one in each clock cycle in which `tick_i` is high, and it does not change in cycles in which `tick_i` is low.
- R3: In counter mode, the counter counts rising edges of `ext_i` when the edge bit is 0 and falling edges when it is 1. Each edge is counted exactly once, after two synchronizer flops.
- R4: With the bypass bit at 0, the counter advances once every 2^(sel+1) count events, where sel is the value of ratio select bits 2:0.
- R5: A write to the low port clears the prescaler count and leaves the control register unchanged.
- R6: After a write to the low port, the next two cycles with `tick_i` high are not counted. Counting resumes on the third tick.
- R7: In 8-bit mode, a low-byte wrap from FFh to 00h sets the overflow flag and leaves the high byte unchanged.
- R8: In 16-bit mode, a wrap from FFFFh to 0000h sets the overflow flag. A carry from 00FFh to 0100h does not set it.
- R9: The overflow flag stays set until a status write with bit 0 at 0. `irq_o` is high exactly when both the flag and the interrupt enable are 1.
- R10: A read of the low port copies the live high byte into the high buffer. A read of the high port then returns that copy.
- R11: A write to the high port changes only the buffer. A following low-port write loads the buffer into the high byte and the data into the low byte together.
- R12: With the run bit at 0, neither the counter nor the prescaler advances. Register reads and writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Instruction-cycle tick enable |
| ext_i | input | 1 | Asynchronous external count input |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
Timer mode is tried with a continuous tick and with a tick that alternates high and low. Comparing the two shows that the counter follows the tick itself and not the clock.

Random trials pick a preload value, a bypass setting, a ratio and a tick count. The expected value is computed from the ratio and the two-tick stall after the write. An error in the divide ratio or in the length of the stall therefore shows up as a wrong count.

Counter mode is driven with an odd pattern of pin edges. The rising and falling settings then expect different totals, so swapping the edges is caught.

Directed cases cover:
- wraps at FFh, FFFFh and 00FFh;
- prescaler clearing, where a missing clear leaves the counter one step ahead;
- a freeze with a half-filled prescaler;
- buffer-only high writes.

// File: rtl/tcu_pkg.sv
// Package: shared types and register addresses for the timer-counter unit.
// Assumes an 8-bit control register whose field order matches tcu_ctrl_t.
package tcu_pkg;
    typedef struct packed {
        logic       run;
        logic       byte_mode;
        logic       ext_src;
        logic       fall_edge;
        logic       pre_bypass;
        logic [2:0] ratio_sel;
    } tcu_ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam logic [7:0] CTRL_RESET = 8'hFF;
endpackage

// File: rtl/tcu_edge_sync.sv
// Module: synchronizes an asynchronous pin and produces a one-cycle pulse
// on the selected edge. Assumes the pin is slower than the clock, holding
// each level for more than STAGES+1 cycles.
module tcu_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    logic [STAGES:0] chain_q;

    // First flop samples the pin directly.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin_i;
    end

    // Remaining flops extend the chain; the last one holds the previous level.
    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    logic cur_lvl, prev_lvl;
    assign cur_lvl  = chain_q[STAGES-1];
    assign prev_lvl = chain_q[STAGES];

    // Edge pulse for the selected direction.
    always_comb begin
        if (fall_sel_i) edge_o = prev_lvl & ~cur_lvl;
        else            edge_o = cur_lvl & ~prev_lvl;
    end

    // R3: a single edge yields one pulse, unless the edge selection changes.
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (!edge_o || (fall_sel_i != $past(fall_sel_i))));
endmodule

// File: rtl/tcu_prescaler.sv
// Module: hidden power-of-two prescaler. Emits one output event per 2^(sel+1)
// input events, or passes events straight through when bypassed.
// Assumes sel_i+1 <= PRE_W.
module tcu_prescaler #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             clr_i,
    input  logic             bypass_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             out_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Mask of the low sel+1 bits that must all be ones for an output event.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(sel_i));
    end

    // Output event selection.
    always_comb begin
        if (bypass_i) out_o = evt_i;
        else          out_o = evt_i && ((pre_q & mask) == mask);
    end

    // Prescaler count: clear has priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pre_q <= '0;
        else if (clr_i)              pre_q <= '0;
        else if (evt_i && !bypass_i) pre_q <= pre_q + 1'b1;
    end

    // R5: a clear always leaves the prescaler empty.
    assert_pre_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pre_q == '0));
    // R12: without input events the prescaler holds its count.
    assert_pre_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/tcu_count_core.sv
// Module: the 2*DATA_W-bit counter with a post-load stall and wrap detection.
// Assumes load_i and inc_i come from the same clock domain. Load has priority.
module tcu_count_core #(
    parameter int DATA_W = 8,
    parameter int STALL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              byte_mode_i,
    input  logic              inc_i,
    input  logic              load_i,
    input  logic [2*DATA_W-1:0] load_val_i,
    output logic [2*DATA_W-1:0] cnt_o,
    output logic              blocked_o,
    output logic              wrap_o
);
    localparam int ST_W = $clog2(STALL + 1);
    localparam int CW   = 2 * DATA_W;

    logic [ST_W-1:0] stall_q;
    logic [CW-1:0]   cnt_q;

    // Stall window: reloaded on every load, consumed one tick at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)                        stall_q <= '0;
        else if (load_i)                   stall_q <= ST_W'(STALL);
        else if (tick_i && stall_q != '0)  stall_q <= stall_q - 1'b1;
    end

    assign blocked_o = (stall_q != '0);

    // Counter: load, or increment in the selected width.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (inc_i) begin
            if (byte_mode_i) cnt_q[DATA_W-1:0] <= cnt_q[DATA_W-1:0] + 1'b1;
            else             cnt_q <= cnt_q + 1'b1;
        end
    end

    // Wrap detection for the active width.
    always_comb begin
        if (byte_mode_i) wrap_o = inc_i && !load_i && (&cnt_q[DATA_W-1:0]);
        else             wrap_o = inc_i && !load_i && (&cnt_q);
    end

    assign cnt_o = cnt_q;

    // R11: a load places both bytes at once.
    assert_load_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));
    // R6: a load opens a stall window.
    assert_stall_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> blocked_o);
    // R7: byte mode never moves the high byte.
    assert_byte_hi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && byte_mode_i) |=> (cnt_q[CW-1:DATA_W] == $past(cnt_q[CW-1:DATA_W])));
endmodule

// File: rtl/tcu_top.sv
// Module: top of the timer-counter unit. Holds the control, high buffer and
// status registers, decodes the byte bus, and joins source selection,
// stall gating, prescaler and counter. Assumes single-cycle bus strobes and
// combinational read data.
module tcu_top
    import tcu_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PRE_W       = 8,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int STALL_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ext_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int CW = 2 * DATA_W;

    tcu_ctrl_t          ctrl_q;
    logic [DATA_W-1:0]  hbuf_q;
    logic               flag_q;
    logic               ie_q;
    logic [CW-1:0]      cnt;
    logic               edge_evt, blocked, wrap, pre_out;
    logic               src_evt, gated_evt;
    logic               wr_ctrl, wr_lo, wr_hi, wr_stat, rd_lo;

    assign wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_CTRL);
    assign wr_lo   = bus_wr_i && (bus_addr_i == ADDR_LO);
    assign wr_hi   = bus_wr_i && (bus_addr_i == ADDR_HI);
    assign wr_stat = bus_wr_i && (bus_addr_i == ADDR_STAT);
    assign rd_lo   = bus_rd_i && (bus_addr_i == ADDR_LO);

    tcu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_i),
        .fall_sel_i(ctrl_q.fall_edge), .edge_o(edge_evt)
    );

    // Count source selection, then run and stall gating.
    always_comb begin
        src_evt   = ctrl_q.ext_src ? edge_evt : tick_i;
        gated_evt = src_evt && ctrl_q.run && !blocked;
    end

    tcu_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .evt_i(gated_evt), .clr_i(wr_lo),
        .bypass_i(ctrl_q.pre_bypass), .sel_i(ctrl_q.ratio_sel), .out_o(pre_out)
    );

    tcu_count_core #(.DATA_W(DATA_W), .STALL(STALL_TICKS)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .byte_mode_i(ctrl_q.byte_mode), .inc_i(pre_out), .load_i(wr_lo),
        .load_val_i({hbuf_q, bus_wdata_i}), .cnt_o(cnt),
        .blocked_o(blocked), .wrap_o(wrap)
    );

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= tcu_ctrl_t'(CTRL_RESET);
        else if (wr_ctrl) ctrl_q <= tcu_ctrl_t'(bus_wdata_i);
    end

    // High buffer: written by the bus, or captured from the live high byte on a low read.
    always_ff @(posedge clk) begin
        if (!rst_n)      hbuf_q <= '0;
        else if (wr_hi)  hbuf_q <= bus_wdata_i;
        else if (rd_lo)  hbuf_q <= cnt[CW-1:DATA_W];
    end

    // Interrupt enable and sticky overflow flag; a wrap wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_stat) ie_q <= bus_wdata_i[1];
            if (wrap)                           flag_q <= 1'b1;
            else if (wr_stat && !bus_wdata_i[0]) flag_q <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr_i)
            ADDR_CTRL: bus_rdata_o = ctrl_q;
            ADDR_LO:   bus_rdata_o = cnt[DATA_W-1:0];
            ADDR_HI:   bus_rdata_o = hbuf_q;
            default:   bus_rdata_o = {{(DATA_W-2){1'b0}}, ie_q, flag_q};
        endcase
    end

    assign irq_o = flag_q & ie_q;

    // R7 and R8: a wrap always leaves the flag set.
    assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);
    // R9: the flag is sticky unless a clearing status write occurs.
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_stat && !bus_wdata_i[0])) |=> flag_q);
    // R10: a low read captures the live high byte into the buffer.
    assert_capture_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !wr_hi) |=> (hbuf_q == $past(cnt[CW-1:DATA_W])));
    // R12: with run cleared and no load, the counter holds.
    assert_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_lo) |=> $stable(cnt));
endmodule

// File: tb/tcu_top_tb_top.sv
// Bench: directed corner cases plus seeded random timer trials, checked
// against expected values computed by bench functions.
module tcu_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ext = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;
    int         tests = 0;
    int         fails = 0;

    tcu_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_i(ext),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(2'd1, lo);
        bus_rd(2'd2, hi);
        v = {hi, lo};
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected count after n continuous ticks following a preload (R4, R6).
    function automatic logic [15:0] exp_count(input logic [15:0] v, input int n,
                                              input bit bypass, input int sel);
        int ev, inc;
        ev  = (n > 2) ? n - 2 : 0;
        inc = bypass ? ev : (ev >> (sel + 1));
        return 16'(v + inc);
    endfunction

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        int          seed;
        seed = 32'h1357;
        void'($urandom(seed));
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(2'd0, b); chk("R1 ctrl", 16'(b), 16'h00FF);
        bus_rd(2'd1, b); chk("R1 low", 16'(b), 16'h0000);
        bus_rd(2'd2, b); chk("R1 hbuf", 16'(b), 16'h0000);
        bus_rd(2'd3, b); chk("R1 status", 16'(b), 16'h0000);
        chk("R1 irq", 16'(irq), 16'h0000);

        // R2 timer mode, 16-bit, bypass; alternating tick
        bus_wr(2'd0, 8'h88);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd1, 8'h05);
        run_ticks(2);
        for (int i = 0; i < 10; i++) begin
            tick = (i % 2 == 0);
            @(negedge clk);
        end
        tick = 1'b0;
        rd16(v); chk("R2 gated tick", v, 16'h000A);

        // R6 stall: continuous ticks after preload
        bus_wr(2'd1, 8'h20);
        run_ticks(3);
        rd16(v); chk("R6 third tick counts", v, 16'h0021);
        bus_wr(2'd1, 8'h20);
        run_ticks(2);
        rd16(v); chk("R6 two ticks blocked", v, 16'h0020);

        // R4 maximum ratio
        bus_wr(2'd0, 8'h87);
        bus_wr(2'd1, 8'h00);
        run_ticks(2 + 512);
        rd16(v); chk("R4 ratio 256", v, 16'h0002);

        // R5 prescaler cleared by low write, control kept
        bus_wr(2'd0, 8'h80);
        bus_wr(2'd1, 8'h00);
        run_ticks(3);
        bus_wr(2'd1, 8'h40);
        run_ticks(3);
        rd16(v); chk("R5 prescaler cleared", v, 16'h0040);
        bus_rd(2'd0, b); chk("R5 ctrl kept", 16'(b), 16'h0080);

        // R12 freeze keeps half-filled prescaler
        bus_wr(2'd1, 8'h00);
        run_ticks(3);
        bus_wr(2'd0, 8'h00);
        run_ticks(5);
        rd16(v); chk("R12 frozen counter", v, 16'h0000);
        bus_wr(2'd0, 8'h80);
        run_ticks(1);
        rd16(v); chk("R12 prescaler frozen", v, 16'h0001);
        bus_wr(2'd0, 8'h08);
        bus_wr(2'd1, 8'h77);
        run_ticks(6);
        rd16(v); chk("R12 write while frozen", v, 16'h0077);

        // R7 8-bit wrap keeps high byte
        bus_wr(2'd0, 8'hC8);
        bus_wr(2'd2, 8'h33);
        bus_wr(2'd1, 8'hFE);
        run_ticks(4);
        rd16(v); chk("R7 byte wrap", v, 16'h3300);
        bus_rd(2'd3, b); chk("R7 flag set", 16'(b), 16'h0001);
        chk("R9 irq masked", 16'(irq), 16'h0000);

        // R9 enable then clear
        bus_wr(2'd3, 8'h03);
        chk("R9 irq raised", 16'(irq), 16'h0001);
        run_ticks(3);
        bus_rd(2'd3, b); chk("R9 flag sticky", 16'(b), 16'h0003);
        bus_wr(2'd3, 8'h02);
        bus_rd(2'd3, b); chk("R9 flag cleared", 16'(b), 16'h0002);
        chk("R9 irq dropped", 16'(irq), 16'h0000);

        // R8 16-bit carry without flag, then full wrap
        bus_wr(2'd0, 8'h88);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd1, 8'hFF);
        run_ticks(3);
        rd16(v); chk("R8 carry into high", v, 16'h0100);
        bus_rd(2'd3, b); chk("R8 no flag on carry", 16'(b), 16'h0002);

        // R11 high write touches only buffer; R10 low read recaptures
        bus_wr(2'd2, 8'h55);
        bus_rd(2'd2, b); chk("R11 buffer written", 16'(b), 16'h0055);
        rd16(v); chk("R10 capture live high", v, 16'h0100);

        bus_wr(2'd2, 8'hFF);
        bus_wr(2'd1, 8'hFE);
        rd16(v); chk("R11 atomic load", v, 16'hFFFE);
        run_ticks(4);
        rd16(v); chk("R8 full wrap", v, 16'h0000);
        bus_rd(2'd3, b); chk("R8 flag set", 16'(b), 16'h0003);
        bus_wr(2'd3, 8'h00);

        // R3 counter mode, rising edges, ending high
        tick = 1'b1;
        bus_wr(2'd0, 8'hA8);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd1, 8'h00);
        wait_cyc(4);
        for (int i = 0; i < 3; i++) begin
            ext = 1'b1; wait_cyc(5);
            if (i < 2) begin ext = 1'b0; wait_cyc(5); end
        end
        rd16(v); chk("R3 rising edges", v, 16'h0003);
        // R3 falling edges, starting high
        bus_wr(2'd0, 8'hB8);
        bus_wr(2'd1, 8'h00);
        wait_cyc(4);
        ext = 1'b0; wait_cyc(5);
        ext = 1'b1; wait_cyc(5);
        ext = 1'b0; wait_cyc(5);
        rd16(v); chk("R3 falling edges", v, 16'h0002);
        tick = 1'b0;

        // R4 and R6 random timer trials
        for (int t = 0; t < 20; t++) begin
            logic [15:0] pv;
            bit          byp;
            int          sel, n;
            pv  = 16'($urandom);
            byp = 1'($urandom % 2);
            sel = int'($urandom % 4);
            n   = 2 + int'($urandom % 40);
            bus_wr(2'd0, {4'b1000, byp, 3'(sel)});
            bus_wr(2'd2, pv[15:8]);
            bus_wr(2'd1, pv[7:0]);
            run_ticks(n);
            rd16(v);
            chk("R4 random trial", v, exp_count(pv, n, byp, sel));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule